// File: doc/BRIEF.md
# Branch-Delay Program Counter Sequencer

This block keeps the program counter state for a pipeline whose branches have an architectural delay slot. A taken branch does not redirect the following fetch. The block stores the target and a pending flag. The redirect happens only when the instruction after the branch (the delay-slot instruction) retires. The block also keeps a separate flag that marks whether the instruction now at the program counter is a delay-slot instruction. The pending flag cannot serve this purpose, because it has already been consumed by the time that instruction runs.

On an exception the block fills in a restart address, a delay-slot marker, a cause code and an exception-level bit. It then points the next program counter at the exception vector. The restart address and the delay-slot marker are only written when the exception level is not already set. An exception inside a delay slot records the address of the branch, so the branch is re-executed on return.

Top module: `delay_pc_seq`

## Requirements
- R1: After reset `pc` equals RESET_PC, `nextPc` equals RESET_PC+4, and `epc`, `causeBd`, `causeCode`, `statusExl` and `inDelaySlot` are all zero.
- R2: A retire with no branch pending and no exception moves `nextPc` into `pc` and sets `nextPc` to its old value plus 4.
- R3: A branch request records its target. On the next retire (or a retire in the same cycle), `pc` takes the old `nextPc` (the delay slot) and `nextPc` takes the recorded target.
- R4: `inDelaySlot` becomes 1 on the retire that enters a delay slot and becomes 0 on any retire that advances sequentially.
- R5: An exception while `inDelaySlot` is 1 and `statusExl` is 0 loads `epc` with `pc`-4 and sets `causeBd` to 1.
- R6: An exception while `inDelaySlot` is 0 and `statusExl` is 0 loads `epc` with `pc` and clears `causeBd`.
- R7: Every exception sets `nextPc` to VEC_BASE plus `vecOffset` (12 bits, sign-extended to 64), writes `excCode` (5 bits) into `causeCode`, sets `statusExl` to 1, and leaves `pc` unchanged.
- R8: An exception while `statusExl` is already 1 leaves `epc` and `causeBd` unchanged. `statusExl` never falls except by reset.
- R9: An exception wins over a retire or branch request in the same cycle, and it drops any pending branch. The following retire advances sequentially from the vector.
- R10: A branch request without a retire changes neither `pc` nor `nextPc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retire | input | 1 | Instruction at `pc` completes |
| branchReq | input | 1 | Current instruction is a taken branch |
| branchTarget | input | 64 | Target of the taken branch |
| excReq | input | 1 | Current instruction raises an exception |
| excCode | input | 5 | Cause code for the exception |
| vecOffset | input | 12 | Signed offset from the vector base |
| pc | output | 64 | Address of the current instruction |
| nextPc | output | 64 | Address of the following instruction |
| inDelaySlot | output | 1 | Current instruction is in a delay slot |
| epc | output | 64 | Restart address of the last exception |
| causeBd | output | 1 | Last recorded exception was in a delay slot |
| causeCode | output | 5 | Code of the last exception |
| statusExl | output | 1 | Exception level |

## Verification
The assertions watch several rules on every cycle. They check that the exception level stays set, and that an exception at exception level leaves the restart address and the slot marker alone. They also check that an exception clears the pending branch, that a sequential retire adds four, and that an idle cycle holds the program counter. Only the bench's scenarios show the values that are actually captured: the backed-up restart address in a slot, the sign-extended vector for extreme offsets, and the sequential path taken after a discarded branch. To do this, the bench sweeps every cause code, a set of boundary offsets, and three entry situations.

// File: rtl/delay_pc_pkg.sv
package delay_pc_pkg;
  typedef struct packed {
    logic advance;
    logic takeDelayed;
    logic loadBranch;
    logic excEntry;
    logic saveEpc;
    logic epcBack;
  } seqStrobe_t;
endpackage

// File: rtl/delay_pc_ctrl.sv
module delay_pc_ctrl
  import delay_pc_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retire,
  input  logic              branchReq,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  output seqStrobe_t        strobe,
  output logic              inDelaySlot,
  output logic              causeBd,
  output logic [CODE_W-1:0] causeCode,
  output logic              statusExl
);
  logic branchPend;

  always_comb begin
    strobe.excEntry    = excReq;
    strobe.saveEpc     = excReq && !statusExl;
    strobe.epcBack     = inDelaySlot;
    strobe.loadBranch  = !excReq && branchReq;
    strobe.advance     = !excReq && retire;
    strobe.takeDelayed = !excReq && retire && (branchPend || branchReq);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      branchPend  <= 1'b0;
      inDelaySlot <= 1'b0;
      causeBd     <= 1'b0;
      causeCode   <= '0;
      statusExl   <= 1'b0;
    end else if (excReq) begin
      branchPend <= 1'b0;
      statusExl  <= 1'b1;
      causeCode  <= excCode;
      if (!statusExl) causeBd <= inDelaySlot;
    end else if (retire) begin
      inDelaySlot <= branchPend || branchReq;
      branchPend  <= 1'b0;
    end else if (branchReq) begin
      branchPend <= 1'b1;
    end
  end

  // R8
  exl_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusExl |=> statusExl);
  // R8
  bd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && statusExl) |=> $stable(causeBd));
  // R7
  exl_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (statusExl && causeCode == $past(excCode)));
  // R9
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> !branchPend);
  // R4
  slot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retire && !excReq && !branchReq && !branchPend) |=> !inDelaySlot);
endmodule

// File: rtl/delay_pc_dp.sv
module delay_pc_dp
  import delay_pc_pkg::*;
#(
  parameter int              ADDR_W      = 64,
  parameter int              OFF_W       = 12,
  parameter int              INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC  = 64'hFFFF_FFFF_BFC0_0000,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 64'hFFFF_FFFF_8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic [OFF_W-1:0]  vecOffset,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] epc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] delayedTgt;
  logic [ADDR_W-1:0] redirectTgt;
  logic [ADDR_W-1:0] vectorAddr;

  always_comb begin
    redirectTgt = strobe.loadBranch ? branchTarget : delayedTgt;
    vectorAddr  = VEC_BASE + {{EXT_W{vecOffset[OFF_W-1]}}, vecOffset};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc         <= RESET_PC;
      nextPc     <= RESET_PC + STEP;
      epc        <= '0;
      delayedTgt <= '0;
    end else begin
      if (strobe.loadBranch) delayedTgt <= branchTarget;
      if (strobe.excEntry) begin
        nextPc <= vectorAddr;
        if (strobe.saveEpc) epc <= strobe.epcBack ? pc - STEP : pc;
      end else if (strobe.advance) begin
        pc     <= nextPc;
        nextPc <= strobe.takeDelayed ? redirectTgt : nextPc + STEP;
      end
    end
  end

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.takeDelayed) |=> (nextPc == $past(nextPc) + STEP && pc == $past(nextPc)));
  // R3
  redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeDelayed && !strobe.loadBranch) |=> nextPc == $past(delayedTgt));
  // R8
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.excEntry && !strobe.saveEpc) |=> $stable(epc));
  // R10
  pc_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.excEntry) |=> ($stable(pc) && $stable(nextPc)));
  // R7
  pc_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.excEntry |=> $stable(pc));
endmodule

// File: rtl/delay_pc_seq.sv
module delay_pc_seq
  import delay_pc_pkg::*;
#(
  parameter int                ADDR_W      = 64,
  parameter int                OFF_W       = 12,
  parameter int                CODE_W      = 5,
  parameter int                INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC    = 64'hFFFF_FFFF_BFC0_0000,
  parameter logic [ADDR_W-1:0] VEC_BASE    = 64'hFFFF_FFFF_8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retire,
  input  logic              branchReq,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic [OFF_W-1:0]  vecOffset,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] nextPc,
  output logic              inDelaySlot,
  output logic [ADDR_W-1:0] epc,
  output logic              causeBd,
  output logic [CODE_W-1:0] causeCode,
  output logic              statusExl
);
  seqStrobe_t strobe;

  delay_pc_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .retire(retire), .branchReq(branchReq),
    .excReq(excReq), .excCode(excCode), .strobe(strobe),
    .inDelaySlot(inDelaySlot), .causeBd(causeBd), .causeCode(causeCode),
    .statusExl(statusExl)
  );

  delay_pc_dp #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .INSTR_BYTES(INSTR_BYTES),
    .RESET_PC(RESET_PC), .VEC_BASE(VEC_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .branchTarget(branchTarget),
    .vecOffset(vecOffset), .pc(pc), .nextPc(nextPc), .epc(epc)
  );
endmodule

// File: tb/delay_pc_seq_bench.sv
module delay_pc_seq_bench;
  localparam logic [63:0] RST_PC = 64'hFFFF_FFFF_BFC0_0000;
  localparam logic [63:0] VBASE  = 64'hFFFF_FFFF_8000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retire = 1'b0, branchReq = 1'b0, excReq = 1'b0;
  logic [63:0] branchTarget = '0;
  logic [4:0]  excCode = '0;
  logic [11:0] vecOffset = '0;
  logic [63:0] pc, nextPc, epc;
  logic inDelaySlot, causeBd, statusExl;
  logic [4:0] causeCode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [63:0] mPc, mNext, mTgt, mEpc;
  logic mDelay, mBp, mBd, mExl;
  logic [4:0] mCode;

  always #4 clk = ~clk;

  delay_pc_seq #(.RESET_PC(RST_PC), .VEC_BASE(VBASE)) u_delay_pc_seq (
    .clk(clk), .rstN(rstN), .retire(retire), .branchReq(branchReq),
    .branchTarget(branchTarget), .excReq(excReq), .excCode(excCode),
    .vecOffset(vecOffset), .pc(pc), .nextPc(nextPc), .inDelaySlot(inDelaySlot),
    .epc(epc), .causeBd(causeBd), .causeCode(causeCode), .statusExl(statusExl)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "pc", pc, mPc);
    chk(tag, "nextPc", nextPc, mNext);
    chk(tag, "inDelaySlot", 64'(inDelaySlot), 64'(mDelay));
    chk(tag, "epc", epc, mEpc);
    chk(tag, "causeBd", 64'(causeBd), 64'(mBd));
    chk(tag, "causeCode", 64'(causeCode), 64'(mCode));
    chk(tag, "statusExl", 64'(statusExl), 64'(mExl));
  endtask

  task automatic doReset();
    rstN = 1'b0; retire = 0; branchReq = 0; excReq = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    mPc = RST_PC; mNext = RST_PC + 64'd4; mTgt = '0; mEpc = '0;
    mDelay = 0; mBp = 0; mBd = 0; mExl = 0; mCode = '0;
    checkAll("R1");
  endtask

  task automatic step(input string tag, input logic r, input logic b, input logic [63:0] t,
                      input logic e, input logic [4:0] c, input logic [11:0] o);
    retire = r; branchReq = b; branchTarget = t; excReq = e; excCode = c; vecOffset = o;
    @(negedge clk);
    if (e) begin
      if (!mExl) begin
        mEpc = mDelay ? mPc - 64'd4 : mPc;
        mBd = mDelay;
      end
      mCode = c; mExl = 1'b1; mBp = 1'b0;
      mNext = VBASE + {{52{o[11]}}, o};
    end else if (r) begin
      mPc = mNext;
      if (mBp || b) begin
        mNext = b ? t : mTgt;
        mDelay = 1'b1;
      end else begin
        mNext = mNext + 64'd4;
        mDelay = 1'b0;
      end
      mBp = 1'b0;
    end else if (b) begin
      mBp = 1'b1; mTgt = t;
    end
    retire = 0; branchReq = 0; excReq = 0;
    checkAll(tag);
  endtask

  initial begin
    logic [11:0] offs [5];
    offs[0] = 12'h800; offs[1] = 12'hFFF; offs[2] = 12'h000; offs[3] = 12'h001; offs[4] = 12'h7FF;
    for (int oi = 0; oi < 5; oi++) begin
      for (int code = 0; code < 32; code++) begin
        for (int mode = 0; mode < 3; mode++) begin
          logic [63:0] t1, t2;
          t1 = 64'h0000_0000_0040_0000 + 64'(code * 256 + oi * 16);
          t2 = 64'h0000_0000_1000_0000 + 64'(mode * 64 + code * 4);
          doReset();
          step("R2", 1, 0, '0, 0, '0, '0);
          step("R3", 1, 1, t1, 0, '0, '0);         // same-cycle branch, into slot (R4 set)
          step("R4", 1, 0, '0, 0, '0, '0);         // slot retires, pc = t1, flag clears
          step("R10", 0, 1, t2, 0, '0, '0);        // branch request alone
          if (mode == 0) begin
            step("R6", 1, 1, 64'h1234, 1, 5'(code), offs[oi]); // R9 exc beats retire/branch
            step("R9", 1, 0, '0, 0, '0, '0);       // pending dropped: sequential from vector
          end else if (mode == 1) begin
            step("R3", 1, 0, '0, 0, '0, '0);       // enter delay slot
            step("R5", 0, 0, '0, 1, 5'(code), offs[oi]);
            step("R7", 1, 0, '0, 0, '0, '0);
          end else begin
            step("R3", 1, 0, '0, 0, '0, '0);
            step("R7", 0, 0, '0, 1, 5'(code), offs[oi]);
            step("R8", 0, 0, '0, 1, 5'(31 - code), offs[4 - oi]);
            step("R8", 1, 0, '0, 0, '0, '0);
          end
        end
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule